// File: doc/BRIEF.md
# SAR Converter Readout Port

This block is the digital half of a 16-bit successive-approximation converter. The analog core is stood in for by a parallel result bus and a done strobe. The block turns an active-low chip-select and an active-low read/convert input into conversion starts and read windows. It drives an active-low busy flag for the length of each conversion and keeps the last completed result in a storage register. It sends that result out serially, most significant bit first.

The serial output works in one of two ways, chosen by a mode input. In the first, the port makes its own data clock: every conversion start sends a burst of 16 clock pulses that carry the previous result. In the second, a host supplies the data clock and opens a read window with the control pins. In that case a leading sync pulse appears only if the host clock toggled while no read was open. A tag input is latched at the start of each read and placed after the data word. In host-clock mode the tag input then keeps flowing through to the output. This lets several ports be chained on one serial line, with a null bit separating the words.

All pins are sampled into a fast system-clock domain, and every edge is detected there. A conversion lasts a fixed, parameterised number of system cycles, and the core model must raise its done strobe in the last of those cycles.

Top module: `sar_readout_port`

## Requirements
- R1: Chip-select and read/convert combine into one active-low select. A conversion starts on the falling edge of that select, which is the moment the later of the two goes low. busy_n falls on the third rising system-clock edge after that input change. A falling select is ignored while a conversion is already running.
- R2: busy_n stays low for exactly CONV_CYCLES system cycles. conv_start pulses high for one cycle as busy_n falls. core_done is only legal in the last busy cycle, and core_result is captured into storage at the end of that cycle.
- R3: Every read, in either mode, returns the result stored before the read began, even if a new conversion finishes during the read.
- R4: The serial word is sent MSB first. With fmt_sb high, bit 15 of the stored value is inverted (straight binary from two's complement). With fmt_sb low, the value is sent unchanged.
- R5: With ext_clk_sel low, each conversion start produces exactly 16 pulses on dclk_out. Each pulse is INT_HALF cycles low followed by INT_HALF cycles high. The data changes only as the clock falls, and dclk_out rests low outside a burst. With ext_clk_sel high, dclk_out stays low.
- R6: After the 16th data bit, sdata shows the tag_in level that was latched when the read began.
- R7: With ext_clk_sel high, a read window opens on a rising read/convert while chip-select is low, or on a falling chip-select while read/convert is high. It closes when either condition is lost.
- R8: In host-clock mode, sync_out goes high on the first rising dclk_in of a read only if at least one rising dclk_in occurred outside a read since the last read began. sync_out falls on the next rising edge, which presents the MSB. Without such an edge, the first rising edge presents the MSB and sync_out stays low.
- R9: In host-clock mode, once the null bit is out, each further rising dclk_in copies the current tag_in to sdata while the read window stays open.
- R10: While pwr_dn is high, conversion starts are ignored: busy_n stays high, no clock burst is sent, and the stored result is kept.
- R11: result_ok is low after reset and stays low through the first conversion. It goes high when a later conversion completes with core_done present.
- R12: After reset, busy_n is high and conv_start, dclk_out, sdata, sync_out and result_ok are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rc_n | input | 1 | Read/convert: a low level requests a conversion, a high level requests a read |
| ext_clk_sel | input | 1 | High: host-supplied data clock; low: internal burst clock |
| dclk_in | input | 1 | Host data clock |
| tag_in | input | 1 | Chain input, placed after the data word |
| fmt_sb | input | 1 | High: invert the MSB (straight binary) |
| pwr_dn | input | 1 | Power-down, blocks conversion starts |
| core_result | input | DATA_W | Result from the analog core model |
| core_done | input | 1 | Core result valid strobe |
| conv_start | output | 1 | One-cycle conversion start to the core |
| busy_n | output | 1 | Low while a conversion runs |
| dclk_out | output | 1 | Internally generated data clock |
| sdata | output | 1 | Serial data |
| sync_out | output | 1 | Leading sync pulse in host-clock mode |
| result_ok | output | 1 | Stored result comes from a valid conversion |

## Verification
Every pin passes through two synchroniser stages and one edge register. A change on cs_n, rc_n or dclk_in therefore shows on busy_n, conv_start, sdata or sync_out at the third rising system edge after the change. The bench drives every input on a falling edge. It checks the start latency on the second and third falling edges after the change, and it reads serial data four falling edges after each host clock transition. The busy window is measured by counting falling edges at which busy_n is low, which must equal CONV_CYCLES. The internal burst is traced on every falling edge: the bench counts rising pulses and high cycles and collects sdata at each rise.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;

  // Pin bundle carried through the synchroniser as one vector.
  typedef struct packed {
    logic pdn;
    logic ext;
    logic fmt;
    logic tag;
    logic dclk;
    logic rc_n;
    logic cs_n;
  } port_ctl_t;

  localparam int unsigned CTL_BITS = $bits(port_ctl_t);

  // Idle levels: selects deasserted, everything else low.
  localparam port_ctl_t CTL_IDLE = '{pdn: 1'b0, ext: 1'b0, fmt: 1'b0, tag: 1'b0,
                                     dclk: 1'b0, rc_n: 1'b1, cs_n: 1'b1};

endpackage

// File: rtl/sar_sync_bank.sv
module sar_sync_bank #(
  parameter int unsigned N      = 7,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d_in,
  output logic [N-1:0] q_out
);

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [N-1:0] q;
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) q <= RST_VAL;
          else     q <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) q <= RST_VAL;
          else     q <= g_stage[g-1].q;
        end
      end
    end
  endgenerate

  assign q_out = g_stage[STAGES-1].q;

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int unsigned W           = 16,
  parameter int unsigned CONV_CYCLES = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_s,
  input  logic         rc_s,
  input  logic         pdn_s,
  input  logic [W-1:0] core_result,
  input  logic         core_done,
  output logic         start_evt,
  output logic         conv_start,
  output logic         busy_n,
  output logic [W-1:0] store_q,
  output logic         result_ok
);

  localparam int unsigned CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

  logic          sel_prev;
  logic          sel_now;
  logic          busy_q;
  logic          start_q;
  logic [CW-1:0] cnt;
  logic          seen_one;
  logic          ok_q;

  // Both selects are active low; the OR is low only when both are low.
  assign sel_now   = cs_s | rc_s;
  assign start_evt = sel_prev & ~sel_now & ~pdn_s & busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_prev <= 1'b1;
      busy_q   <= 1'b1;
      start_q  <= 1'b0;
      cnt      <= '0;
      store_q  <= '0;
      seen_one <= 1'b0;
      ok_q     <= 1'b0;
    end else begin
      sel_prev <= sel_now;
      start_q  <= start_evt;
      if (start_evt) begin
        busy_q <= 1'b0;
        cnt    <= '0;
      end else if (!busy_q) begin
        if (cnt == LAST) begin
          busy_q   <= 1'b1;
          store_q  <= core_result;
          seen_one <= 1'b1;
          ok_q     <= seen_one & core_done;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign busy_n     = busy_q;
  assign conv_start = start_q;
  assign result_ok  = ok_q;

  AST_DONE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    core_done |-> (!busy_q && cnt == LAST)); // R2
  AST_STORE_HELD: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && cnt != LAST) |=> $stable(store_q)); // R3
  AST_PDN_NO_START: assert property (@(posedge clk) disable iff (rst)
    (pdn_s && busy_q) |=> busy_q); // R10
  AST_OK_AT_COMPLETION: assert property (@(posedge clk) disable iff (rst)
    $rose(ok_q) |-> $rose(busy_q)); // R11

endmodule

// File: rtl/sar_ser_out.sv
module sar_ser_out #(
  parameter int unsigned W        = 16,
  parameter int unsigned INT_HALF = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ext_s,
  input  logic         cs_s,
  input  logic         rc_s,
  input  logic         dclk_s,
  input  logic         tag_s,
  input  logic         fmt_s,
  input  logic         start_evt,
  input  logic [W-1:0] store_q,
  output logic         dclk_out,
  output logic         sdata,
  output logic         sync_out
);

  localparam int unsigned NW = $clog2(W + 2);
  localparam int unsigned HW = (INT_HALF > 1) ? $clog2(INT_HALF) : 1;
  localparam logic [NW-1:0] LAST_BIT = NW'(W - 1);
  localparam logic [NW-1:0] NULL_IDX = NW'(W);
  localparam logic [NW-1:0] PASS_IDX = NW'(W + 1);
  localparam logic [HW-1:0] HLAST    = HW'(INT_HALF - 1);

  logic [W-1:0]  fmt_word;
  logic [W-1:0]  sh;
  logic [NW-1:0] nbit;
  logic [HW-1:0] ph;
  logic          tag_lat;
  logic          sdata_q;
  logic          sync_q;
  logic          dclk_q;
  logic          burst_on;
  logic          rd_on;
  logic          pend_sync;
  logic          ran_outside;
  logic          dclk_prev;
  logic          cs_prev;
  logic          rc_prev;
  logic          dclk_rise;
  logic          read_cmd;
  logic          read_hold;

  assign fmt_word  = {store_q[W-1] ^ fmt_s, store_q[W-2:0]};
  assign dclk_rise = dclk_s & ~dclk_prev;
  assign read_cmd  = ext_s & ((rc_s & ~rc_prev & ~cs_s) | (~cs_s & cs_prev & rc_s));
  assign read_hold = ext_s & ~cs_s & rc_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh          <= '0;
      nbit        <= '0;
      ph          <= '0;
      tag_lat     <= 1'b0;
      sdata_q     <= 1'b0;
      sync_q      <= 1'b0;
      dclk_q      <= 1'b0;
      burst_on    <= 1'b0;
      rd_on       <= 1'b0;
      pend_sync   <= 1'b0;
      ran_outside <= 1'b0;
      dclk_prev   <= 1'b0;
      cs_prev     <= 1'b1;
      rc_prev     <= 1'b1;
    end else begin
      dclk_prev <= dclk_s;
      cs_prev   <= cs_s;
      rc_prev   <= rc_s;
      if (!ext_s) begin
        // Internal clock: one burst per conversion start.
        rd_on       <= 1'b0;
        sync_q      <= 1'b0;
        pend_sync   <= 1'b0;
        ran_outside <= 1'b0;
        if (start_evt) begin
          sh       <= fmt_word;
          sdata_q  <= fmt_word[W-1];
          tag_lat  <= tag_s;
          nbit     <= '0;
          ph       <= '0;
          dclk_q   <= 1'b0;
          burst_on <= 1'b1;
        end else if (burst_on) begin
          if (ph == HLAST) begin
            ph <= '0;
            if (!dclk_q) begin
              dclk_q <= 1'b1;
            end else begin
              dclk_q <= 1'b0;
              if (nbit == LAST_BIT) begin
                burst_on <= 1'b0;
                sdata_q  <= tag_lat;
                nbit     <= NULL_IDX;
              end else begin
                sh      <= sh << 1;
                sdata_q <= sh[W-2];
                nbit    <= nbit + 1'b1;
              end
            end
          end else begin
            ph <= ph + 1'b1;
          end
        end
      end else begin
        // Host clock: read windows opened by the control pins.
        burst_on <= 1'b0;
        dclk_q   <= 1'b0;
        ph       <= '0;
        if (read_cmd) begin
          rd_on       <= 1'b1;
          sh          <= fmt_word;
          tag_lat     <= tag_s;
          nbit        <= '0;
          pend_sync   <= ran_outside;
          ran_outside <= 1'b0;
          sync_q      <= 1'b0;
        end else if (rd_on && !read_hold) begin
          rd_on     <= 1'b0;
          sync_q    <= 1'b0;
          pend_sync <= 1'b0;
        end else if (rd_on && dclk_rise) begin
          if (pend_sync) begin
            sync_q    <= 1'b1;
            pend_sync <= 1'b0;
          end else begin
            sync_q <= 1'b0;
            if (nbit < NULL_IDX) begin
              sdata_q <= sh[W-1];
              sh      <= sh << 1;
              nbit    <= nbit + 1'b1;
            end else if (nbit == NULL_IDX) begin
              sdata_q <= tag_lat;
              nbit    <= PASS_IDX;
            end else begin
              sdata_q <= tag_s;
            end
          end
        end else if (!rd_on && dclk_rise) begin
          ran_outside <= 1'b1;
        end
      end
    end
  end

  assign dclk_out = dclk_q;
  assign sdata    = sdata_q;
  assign sync_out = sync_q;

  AST_NO_CLK_IN_EXT: assert property (@(posedge clk) disable iff (rst)
    (ext_s && $past(ext_s)) |-> !dclk_q); // R5
  AST_DATA_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (!ext_s && !start_evt && dclk_q) |=> ($stable(sdata_q) || !dclk_q)); // R5
  AST_SYNC_IN_READ: assert property (@(posedge clk) disable iff (rst)
    sync_q |-> rd_on); // R8
  AST_BIT_INDEX_RANGE: assert property (@(posedge clk) disable iff (rst)
    nbit <= PASS_IDX); // R6

endmodule

// File: rtl/sar_readout_port.sv
module sar_readout_port #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CONV_CYCLES = 24,
  parameter int unsigned INT_HALF    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rc_n,
  input  logic              ext_clk_sel,
  input  logic              dclk_in,
  input  logic              tag_in,
  input  logic              fmt_sb,
  input  logic              pwr_dn,
  input  logic [DATA_W-1:0] core_result,
  input  logic              core_done,
  output logic              conv_start,
  output logic              busy_n,
  output logic              dclk_out,
  output logic              sdata,
  output logic              sync_out,
  output logic              result_ok
);

  import sar_port_pkg::*;

  port_ctl_t          ctl_raw;
  port_ctl_t          ctl_s;
  logic               start_evt;
  logic [DATA_W-1:0]  store_q;

  assign ctl_raw = '{pdn: pwr_dn, ext: ext_clk_sel, fmt: fmt_sb, tag: tag_in,
                     dclk: dclk_in, rc_n: rc_n, cs_n: cs_n};

  sar_sync_bank #(
    .N       (CTL_BITS),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (CTL_IDLE)
  ) i_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (ctl_raw),
    .q_out (ctl_s)
  );

  sar_conv_ctrl #(
    .W           (DATA_W),
    .CONV_CYCLES (CONV_CYCLES)
  ) i_conv (
    .clk         (clk),
    .rst         (rst),
    .cs_s        (ctl_s.cs_n),
    .rc_s        (ctl_s.rc_n),
    .pdn_s       (ctl_s.pdn),
    .core_result (core_result),
    .core_done   (core_done),
    .start_evt   (start_evt),
    .conv_start  (conv_start),
    .busy_n      (busy_n),
    .store_q     (store_q),
    .result_ok   (result_ok)
  );

  sar_ser_out #(
    .W        (DATA_W),
    .INT_HALF (INT_HALF)
  ) i_ser (
    .clk       (clk),
    .rst       (rst),
    .ext_s     (ctl_s.ext),
    .cs_s      (ctl_s.cs_n),
    .rc_s      (ctl_s.rc_n),
    .dclk_s    (ctl_s.dclk),
    .tag_s     (ctl_s.tag),
    .fmt_s     (ctl_s.fmt),
    .start_evt (start_evt),
    .store_q   (store_q),
    .dclk_out  (dclk_out),
    .sdata     (sdata),
    .sync_out  (sync_out)
  );

endmodule

// File: tb/test_sar_readout_port.sv
module test_sar_readout_port;

  localparam int W    = 16;
  localparam int CONV = 24;
  localparam int HALF = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, cs_n, rc_n, ext_clk_sel, dclk_in, tag_in, fmt_sb, pwr_dn, core_done;
  logic [W-1:0] core_result;
  logic conv_start, busy_n, dclk_out, sdata, sync_out, result_ok;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] next_val;
  logic [W-1:0] model_store;

  sar_readout_port #(.DATA_W(W), .CONV_CYCLES(CONV), .INT_HALF(HALF), .SYNC_STAGES(2)) i_sar_readout_port (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rc_n(rc_n), .ext_clk_sel(ext_clk_sel),
    .dclk_in(dclk_in), .tag_in(tag_in), .fmt_sb(fmt_sb), .pwr_dn(pwr_dn),
    .core_result(core_result), .core_done(core_done), .conv_start(conv_start),
    .busy_n(busy_n), .dclk_out(dclk_out), .sdata(sdata), .sync_out(sync_out),
    .result_ok(result_ok)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Analog core model: result lands in the last busy cycle.
  initial begin
    core_done = 1'b0;
    core_result = '0;
    model_store = '0;
    forever begin
      @(negedge clk);
      if (conv_start === 1'b1) begin
        repeat (CONV - 1) @(negedge clk);
        core_result = next_val;
        core_done = 1'b1;
        @(negedge clk);
        core_done = 1'b0;
        model_store = next_val;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  task automatic ext_pulse(output logic d, output logic s);
    dclk_in = 1'b1;
    idle(4);
    d = sdata;
    s = sync_out;
    dclk_in = 1'b0;
    idle(4);
  endtask

  task automatic t_reset();
    check("R12 busy_n", busy_n, 1);
    check("R12 conv_start", conv_start, 0);
    check("R12 dclk_out", dclk_out, 0);
    check("R12 sdata", sdata, 0);
    check("R12 sync_out", sync_out, 0);
    check("R12 result_ok", result_ok, 0);
  endtask

  task automatic t_start_timing();
    int n;
    cs_n = 1'b0;
    idle(4);
    next_val = 16'h1234;
    rc_n = 1'b0;
    idle(2);
    check("R1 busy before third edge", busy_n, 1);
    idle(1);
    check("R1 busy falls on third edge", busy_n, 0);
    check("R2 conv_start strobe", conv_start, 1);
    n = 1;
    forever begin
      @(negedge clk);
      if (busy_n) break;
      n++;
    end
    check("R2 busy width", n, CONV);
    check("R11 first conversion flagged", result_ok, 0);
    rc_n = 1'b1;
    idle(80);
    next_val = 16'hA5C3;
    rc_n = 1'b0;
    idle(4);
    rc_n = 1'b1;
    idle(80);
    check("R11 second conversion valid", result_ok, 1);
  endtask

  task automatic t_cs_last();
    cs_n = 1'b1;
    idle(4);
    next_val = 16'h0F0F;
    rc_n = 1'b0;
    idle(8);
    check("R1 no start with chip-select high", busy_n, 1);
    cs_n = 1'b0;
    idle(2);
    check("R1 cs second, before third edge", busy_n, 1);
    idle(1);
    check("R1 cs second starts conversion", busy_n, 0);
    idle(CONV + 5);
    rc_n = 1'b1;
    idle(80);
  endtask

  task automatic t_int_burst(input string req, input logic fmt_v, input logic tag_v,
                             input logic [W-1:0] newv);
    logic [W-1:0] prev;
    logic [W-1:0] word;
    logic [W-1:0] expw;
    logic last;
    int rises;
    int highs;
    fmt_sb = fmt_v;
    tag_in = tag_v;
    idle(5);
    prev = model_store;
    next_val = newv;
    rc_n = 1'b0;
    last = 1'b0;
    rises = 0;
    highs = 0;
    word = '0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (i == 5) rc_n = 1'b1;
      if (dclk_out) highs++;
      if (dclk_out && !last) begin
        rises++;
        word = {word[W-2:0], sdata};
      end
      last = dclk_out;
    end
    expw = prev ^ (fmt_v ? 16'h8000 : 16'h0000);
    check({req, " R5 pulse count"}, rises, 16);
    check({req, " R5 high cycles"}, highs, 16 * HALF);
    check({req, " R3 R4 word"}, word, expw);
    check({req, " R6 tag after word"}, sdata, tag_v);
    check({req, " R5 clock rests low"}, dclk_out, 0);
  endtask

  task automatic t_powerdown();
    int rises;
    int starts;
    logic last;
    pwr_dn = 1'b1;
    idle(5);
    rc_n = 1'b0;
    rises = 0;
    starts = 0;
    last = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (conv_start) starts++;
      if (dclk_out && !last) rises++;
      last = dclk_out;
    end
    check("R10 busy held high", busy_n, 1);
    check("R10 no start strobe", starts, 0);
    check("R10 no burst", rises, 0);
    rc_n = 1'b1;
    idle(5);
    pwr_dn = 1'b0;
    idle(5);
    // The next burst must still carry the result stored before power-down.
    t_int_burst("R10 store kept", 1'b0, 1'b1, 16'h1111);
  endtask

  task automatic t_ext_nosync();
    logic d, s;
    logic [W-1:0] word;
    logic [W-1:0] expw;
    int syncs;
    fmt_sb = 1'b0;
    ext_clk_sel = 1'b1;
    idle(5);
    next_val = 16'h3C5A;
    rc_n = 1'b0;
    idle(CONV + 8);
    check("R5 no internal clock in host mode", dclk_out, 0);
    expw = model_store;
    tag_in = 1'b1;
    rc_n = 1'b1;
    idle(5);
    word = '0;
    syncs = 0;
    for (int i = 0; i < W; i++) begin
      ext_pulse(d, s);
      word = {word[W-2:0], d};
      if (s) syncs++;
    end
    check("R8 no sync without outside clock", syncs, 0);
    check("R7 R4 read on rc rise", word, expw);
    tag_in = 1'b0;
    idle(3);
    ext_pulse(d, s);
    check("R6 null bit is latched tag", d, 1);
    ext_pulse(d, s);
    check("R9 tag passes through low", d, 0);
    tag_in = 1'b1;
    idle(3);
    ext_pulse(d, s);
    check("R9 tag passes through high", d, 1);
    next_val = 16'hC001;
    rc_n = 1'b0;
    idle(CONV + 8);
  endtask

  task automatic t_ext_sync();
    logic d, s;
    logic [W-1:0] word;
    logic [W-1:0] expw;
    ext_pulse(d, s);
    fmt_sb = 1'b1;
    idle(3);
    expw = model_store ^ 16'h8000;
    rc_n = 1'b1;
    idle(5);
    ext_pulse(d, s);
    check("R8 sync on first rise", s, 1);
    word = '0;
    for (int i = 0; i < W; i++) begin
      ext_pulse(d, s);
      if (i == 0) check("R8 sync ends as MSB appears", s, 0);
      word = {word[W-2:0], d};
    end
    check("R4 R3 straight binary word after sync", word, expw);
  endtask

  task automatic t_ext_cs();
    logic d, s;
    logic [W-1:0] word;
    int syncs;
    fmt_sb = 1'b0;
    cs_n = 1'b1;
    idle(5);
    cs_n = 1'b0;
    idle(5);
    word = '0;
    syncs = 0;
    for (int i = 0; i < W; i++) begin
      ext_pulse(d, s);
      word = {word[W-2:0], d};
      if (s) syncs++;
    end
    check("R7 read on chip-select fall", word, model_store);
    check("R8 no sync after idle clock", syncs, 0);
  endtask

  initial begin
    rst = 1'b1;
    cs_n = 1'b1;
    rc_n = 1'b1;
    ext_clk_sel = 1'b0;
    dclk_in = 1'b0;
    tag_in = 1'b0;
    fmt_sb = 1'b0;
    pwr_dn = 1'b0;
    next_val = '0;
    idle(5);
    rst = 1'b0;
    idle(3);
    t_reset();
    t_start_timing();
    t_cs_last();
    t_int_burst("internal two's complement", 1'b0, 1'b1, 16'h8001);
    t_int_burst("internal straight binary", 1'b1, 1'b0, 16'h7FFE);
    t_powerdown();
    t_ext_nosync();
    t_ext_sync();
    t_ext_cs();
    finish_run();
  end

endmodule